// File: doc/BRIEF.md
# Abort-Safe Condition Code Commit Unit

This block owns the 16-bit processor status word of a small processor core, and in particular its four condition code bits. For the destination-write instructions (move, clear and sign-extend) it computes the new codes from the operand and the current codes. It writes them into the status word only in the cycle in which the sequencer reports that the last memory write of the instruction has finished. An instruction that is aborted on that write, for example by an address error, therefore leaves the codes exactly as they were. A restarted instruction then sees its original environment.

The status word can also be written directly over the bus, either as a plain store or as the write-back of a set-bits or clear-bits operation. The condition codes carried in such a write always prevail. A commit request that arrives in the cycle right after a bus write to the status word is dropped, because that request belongs to the instruction that did the write. The trace bit cannot be reached through the bus, and bits 10 to 8 always read as zero.

Top module: `cc_commit_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, psw_o reads 16'h0000.
- R2: A committed move (op_i = 2'b00) sets N (bit 3) from the operand sign and Z (bit 2) when the operand is zero. It clears V (bit 1) and keeps C (bit 0).
- R3: With byte_i high, the sign is src_i[7] and the zero test covers src_i[7:0]. With byte_i low, the sign is src_i[15] and the zero test covers all 16 bits.
- R4: A committed clear (op_i = 2'b01) leaves the codes N,Z,V,C = 0,1,0,0, whatever the operand or the width.
- R5: A committed sign-extend (op_i = 2'b10) clears V, keeps N and C, and sets Z exactly when N is clear.
- R6: The codes change only at the clock edge where wr_done_i is high. With wr_done_i low, a presented opcode and operand have no effect.
- R7: When abort_i is high, the codes keep their value from before the instruction, even if wr_done_i is high in the same cycle.
- R8: A bus write (psw_we_i) loads the codes from psw_wdata_i[3:0] at the next edge. This also holds when a commit is requested in the same cycle.
- R9: A commit requested in the cycle immediately after a bus write is ignored. A commit one cycle later is accepted.
- R10: A bus write loads bits 15:11 and 7:5 from psw_wdata_i. It never changes the trace bit (bit 4). Bits 10:8 of psw_o are always zero.
- R11: The opcode 2'b11 never changes the codes, even with wr_done_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Instruction class: 00 move, 01 clear, 10 sign-extend, 11 no update |
| byte_i | input | 1 | Byte-size operation |
| src_i | input | 16 | Value written to the destination |
| wr_done_i | input | 1 | Final destination write completes in this cycle |
| abort_i | input | 1 | Final destination write aborted in this cycle |
| psw_we_i | input | 1 | Bus write strobe for the status word |
| psw_wdata_i | input | 16 | Bus write data for the status word |
| psw_o | output | 16 | Registered status word |

## Verification
The hardest situation to reach is a commit request that lands exactly one cycle after a bus write to the status word. Only there does the suppression flag matter, and one cycle later it must no longer matter. The bench drives a status write, then drives a clear commit on the very next cycle and checks that the written codes survive. It then repeats the commit one cycle later and checks that the codes change. Abort and completion in the same cycle are covered by table vectors that raise both strobes together, each starting from a known, deliberately non-trivial set of codes.

// File: rtl/cc_commit_pkg.sv
package cc_commit_pkg;
  localparam int PSW_W = 16;
  localparam int CC_W  = 4;

  // bit positions inside the status word
  localparam int CC_C  = 0;
  localparam int CC_V  = 1;
  localparam int CC_Z  = 2;
  localparam int CC_N  = 3;
  localparam int T_BIT = 4;

  // bits a bus write may load: 15:11, 7:5, 3:0
  localparam logic [PSW_W-1:0] BUS_WR_MASK = 16'hF8EF;

  typedef enum logic [1:0] {
    OP_MOV  = 2'b00,
    OP_CLR  = 2'b01,
    OP_SXT  = 2'b10,
    OP_NONE = 2'b11
  } cc_op_e;
endpackage

// File: rtl/cc_calc.sv
module cc_calc
  import cc_commit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  cc_op_e            op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [CC_W-1:0]   cc_cur_i,
  output logic [CC_W-1:0]   cc_new_o,
  output logic              upd_o
);
  logic sign, zero;

  always_comb begin
    sign = byte_i ? src_i[BYTE_W-1] : src_i[DATA_W-1];
    zero = byte_i ? (src_i[BYTE_W-1:0] == '0) : (src_i == '0);
  end

  always_comb begin
    cc_new_o = cc_cur_i;
    upd_o    = 1'b1;
    unique case (op_i)
      OP_MOV: begin
        cc_new_o[CC_N] = sign;
        cc_new_o[CC_Z] = zero;
        cc_new_o[CC_V] = 1'b0;
      end
      OP_CLR: cc_new_o = 4'b0100;
      OP_SXT: begin
        cc_new_o[CC_Z] = ~cc_cur_i[CC_N];
        cc_new_o[CC_V] = 1'b0;
      end
      default: upd_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cc_commit_gate.sv
module cc_commit_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic psw_we_i,
  input  logic wr_done_i,
  input  logic abort_i,
  input  logic upd_i,
  output logic cc_we_o
);
  logic we_q;  // status word written in the previous cycle

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b0;
    else         we_q <= psw_we_i;
  end

  // abort wins over done; request dropped right after a bus write
  always_comb cc_we_o = wr_done_i & ~abort_i & upd_i & ~we_q;
endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import cc_commit_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             psw_we_i,
  input  logic [PSW_W-1:0] psw_wdata_i,
  input  logic             cc_we_i,
  input  logic [CC_W-1:0]  cc_new_i,
  output logic [PSW_W-1:0] psw_o
);
  logic [PSW_W-1:0] psw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q <= '0;
    end else if (psw_we_i) begin
      psw_q <= (psw_wdata_i & BUS_WR_MASK) | (psw_q & ~BUS_WR_MASK);
    end else if (cc_we_i) begin
      psw_q[CC_W-1:0] <= cc_new_i;
    end
  end

  assign psw_o = psw_q;
endmodule

// File: rtl/cc_commit_unit.sv
module cc_commit_unit
  import cc_commit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              wr_done_i,
  input  logic              abort_i,
  input  logic              psw_we_i,
  input  logic [PSW_W-1:0]  psw_wdata_i,
  output logic [PSW_W-1:0]  psw_o
);
  logic [CC_W-1:0] cc_new;
  logic            upd;
  logic            cc_we;

  cc_calc #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_calc (
    .op_i     (cc_op_e'(op_i)),
    .byte_i   (byte_i),
    .src_i    (src_i),
    .cc_cur_i (psw_o[CC_W-1:0]),
    .cc_new_o (cc_new),
    .upd_o    (upd)
  );

  cc_commit_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psw_we_i  (psw_we_i),
    .wr_done_i (wr_done_i),
    .abort_i   (abort_i),
    .upd_i     (upd),
    .cc_we_o   (cc_we)
  );

  psw_reg u_psw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .psw_we_i    (psw_we_i),
    .psw_wdata_i (psw_wdata_i),
    .cc_we_i     (cc_we),
    .cc_new_i    (cc_new),
    .psw_o       (psw_o)
  );
endmodule

// File: rtl/cc_commit_unit_chk.sv
module cc_commit_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  op_i,
  input logic        wr_done_i,
  input logic        abort_i,
  input logic        psw_we_i,
  input logic [15:0] psw_wdata_i,
  input logic [15:0] psw_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_o[10:8] == 3'b000); // R10

  AST_TBIT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_we_i |=> psw_o[4] == $past(psw_o[4])); // R10

  AST_BUS_CC_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_we_i |=> psw_o[3:0] == $past(psw_wdata_i[3:0])); // R8

  AST_ABORT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !psw_we_i) |=> $stable(psw_o[3:0])); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_done_i && !psw_we_i) |=> $stable(psw_o[3:0])); // R6

  AST_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(psw_we_i) && !psw_we_i) |=> $stable(psw_o[3:0])); // R9

  AST_NONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'b11 && !psw_we_i) |=> $stable(psw_o[3:0])); // R11

  AST_CLR_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_done_i && !abort_i && !psw_we_i && !$past(psw_we_i) && op_i == 2'b01)
      |=> psw_o[3:0] == 4'b0100); // R4
endmodule

bind cc_commit_unit cc_commit_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .wr_done_i   (wr_done_i),
  .abort_i     (abort_i),
  .psw_we_i    (psw_we_i),
  .psw_wdata_i (psw_wdata_i),
  .psw_o       (psw_o)
);

// File: tb/cc_commit_unit_bench.sv
`timescale 1ns/1ps
module cc_commit_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = 2'b11;
  logic        byte_i = 1'b0;
  logic [15:0] src_i = '0;
  logic        wr_done_i = 1'b0;
  logic        abort_i = 1'b0;
  logic        psw_we_i = 1'b0;
  logic [15:0] psw_wdata_i = '0;
  logic [15:0] psw_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  cc_commit_unit u_cc_commit_unit (.*);

  // {pre_cc[4], op[2], byte, src[16], abort, exp_cc[4]}
  localparam int NV = 15;
  localparam logic [27:0] VEC [NV] = '{
    {4'b1111, 2'b00, 1'b0, 16'h0123, 1'b0, 4'b0001}, // R2 positive word
    {4'b0000, 2'b00, 1'b0, 16'h8000, 1'b0, 4'b1000}, // R2 negative word
    {4'b0011, 2'b00, 1'b0, 16'h0000, 1'b0, 4'b0101}, // R2 zero, keep C
    {4'b0000, 2'b00, 1'b1, 16'hFF80, 1'b0, 4'b1000}, // R3 byte sign bit 7
    {4'b1000, 2'b00, 1'b1, 16'h1200, 1'b0, 4'b0100}, // R3 byte zero low 8
    {4'b0101, 2'b00, 1'b0, 16'h1200, 1'b0, 4'b0001}, // R3 word not zero
    {4'b0000, 2'b00, 1'b0, 16'h0080, 1'b0, 4'b0000}, // R3 word ignores bit 7
    {4'b1011, 2'b01, 1'b0, 16'hFFFF, 1'b0, 4'b0100}, // R4 word
    {4'b0000, 2'b01, 1'b1, 16'h0080, 1'b0, 4'b0100}, // R4 byte
    {4'b1011, 2'b10, 1'b0, 16'hFFFF, 1'b0, 4'b1001}, // R5 N set
    {4'b0010, 2'b10, 1'b0, 16'h0000, 1'b0, 4'b0100}, // R5 N clear
    {4'b0001, 2'b10, 1'b1, 16'h0000, 1'b0, 4'b0101}, // R5 keep C
    {4'b1010, 2'b00, 1'b0, 16'h0000, 1'b1, 4'b1010}, // R7 move aborted
    {4'b0001, 2'b01, 1'b0, 16'h0000, 1'b1, 4'b0001}, // R7 clear aborted
    {4'b0110, 2'b11, 1'b0, 16'h0000, 1'b0, 4'b0110}  // R11 no-update op
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] d);
    @(negedge clk_i);
    psw_we_i = 1'b1; psw_wdata_i = d;
    @(negedge clk_i);
    psw_we_i = 1'b0;
  endtask

  task automatic idle;
    @(negedge clk_i);
    wr_done_i = 1'b0; abort_i = 1'b0; op_i = 2'b11;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", psw_o, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", psw_o, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      bus_write({12'h000, VEC[i][27:24]});
      idle();  // clear the after-write window
      op_i = VEC[i][23:22]; byte_i = VEC[i][21]; src_i = VEC[i][20:5];
      abort_i = VEC[i][4]; wr_done_i = 1'b1;
      @(negedge clk_i);
      wr_done_i = 1'b0; abort_i = 1'b0;
      check($sformatf("R2-R11 vec%0d", i), {12'h000, psw_o[3:0]}, {12'h000, VEC[i][3:0]});
    end

    // R6: opcode presented without completion strobe
    bus_write(16'h000A);
    idle();
    op_i = 2'b01; src_i = 16'h0000;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R6", {12'h000, psw_o[3:0]}, 16'h000A);

    // R9: commit right after bus write dropped, next one accepted
    bus_write(16'h000A);  // ends with we low, commit driven in same cycle
    op_i = 2'b01; wr_done_i = 1'b1;
    @(negedge clk_i);
    check("R9 dropped", {12'h000, psw_o[3:0]}, 16'h000A);
    @(negedge clk_i);
    wr_done_i = 1'b0;
    check("R9 accepted", {12'h000, psw_o[3:0]}, 16'h0004);

    // R8: bus write and commit in the same cycle
    idle();
    psw_we_i = 1'b1; psw_wdata_i = 16'h000F; op_i = 2'b01; wr_done_i = 1'b1;
    @(negedge clk_i);
    psw_we_i = 1'b0; wr_done_i = 1'b0;
    check("R8", {12'h000, psw_o[3:0]}, 16'h000F);

    // R10: writable fields, trace bit and reserved bits
    bus_write(16'hFFFF);
    check("R10 all ones", psw_o, 16'hF8EF);
    bus_write(16'h0710);
    check("R10 tbit/rsvd", psw_o, 16'h0000);
    bus_write(16'hA8A5);
    check("R10 fields", psw_o, 16'hA8A5);

    // R1: reset in mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 mid-run", psw_o, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 release", psw_o, 16'h0000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule